// File: doc/BRIEF.md
# Parallel FIR Slice Array

This block runs a real FIR filter with a parameterised number of taps on a row of eight multiply-accumulate slices. Each slice builds a different output sample of the same pass. Slice `j` of a pass based at sample index `n` produces `y[n+j] = sum over k of h[k] * x[n+j-k]`. Every compute cycle reads one coefficient from an internal register file and sends that same value to all slices. The sample register in each slice takes the value its left neighbour held, and slice 0 takes one sample from the history store. Each compute cycle therefore needs only one coefficient fetch and one sample fetch, however many slices there are.

A pass has three phases. First the block takes eight new samples from a valid/ready input stream into a history store that is `P+TAPS-1` samples deep. Then it spends one cycle preloading the slice registers and `TAPS` cycles accumulating into 40-bit accumulators. Last, it sends the eight results, oldest first, on a valid/ready output stream. The next pass begins with `n` advanced by eight. Coefficients are written through a simple address/data write port, and this is done between passes.

Top module: `pfir_slice_array`

## Requirements
- R1: While reset is asserted, and until two clock edges after it is released, in_ready and out_valid are low. After that, in_ready is high. The history store and the coefficient register file start at zero, so the first pass gives all-zero results until coefficients are written.
- R2: A pass accepts exactly P=8 samples. A sample is taken on each edge where in_valid and in_ready are both high. After the 8th sample is taken, in_ready stays low until the last output of that pass has been accepted.
- R3: Each output equals the sum over k=0..TAPS-1 of h[k]*x[n+j-k]. Coefficients and samples are signed 16-bit two's complement values. Samples from before the first one accepted after reset count as zero. The sum is carried in 40-bit two's complement.
- R4: The eight outputs of a pass appear in order y[n], y[n+1], ..., y[n+7]. Here y[n] belongs to the oldest of the eight samples taken in that pass.
- R5: out_valid first goes high exactly TAPS+1 clock edges after the edge that took the 8th sample of the pass. These are one preload cycle and TAPS accumulate cycles.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R7: When coef_we is high, coef_data is written to entry coef_addr (6-bit address, entry k holds h[k]), provided coef_addr < TAPS. A write with coef_addr >= TAPS changes no coefficient.
- R8: Each pass uses a fresh accumulation with no carry-over from the previous pass. Its base index is the previous base plus 8, so the history runs on without a gap across passes.
- R9: in_ready and out_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 6 | Coefficient index k |
| coef_data | input | CW (16) | Signed coefficient value |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DW (16) | Signed input sample |
| out_valid | output | 1 | Output result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | AW (40) | Signed filter output |

## Verification
The bound checker checks the handshake rules on every cycle. These are: the input closes after exactly eight samples (R2), the input reopens after eight outputs (R4), the two streams never open together (R9), outputs hold while stalled (R6), the preload-plus-TAPS latency (R5), and out-of-range coefficient writes leave the register file unchanged (R7). The arithmetic can only be shown by the bench's scenarios. These scenarios are impulse and ramp data for ordering, full-scale negative operands for the 40-bit sum, and several passes in a row for history continuity and accumulator clearing. Each is compared against a behavioural model on every clock, with random gaps on the input and random stalls on the output.

// File: rtl/pfir_pkg.sv
package pfir_pkg;
  typedef enum logic [1:0] {ST_FILL, ST_LOAD, ST_RUN, ST_EMIT} pfir_state_e;
  localparam int MAX_TAPS = 64;
  localparam int CADDR_W  = 6;
endpackage

// File: rtl/pfir_coef_bank.sv
module pfir_coef_bank #(
  parameter int TAPS = 5,
  parameter int CW   = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [pfir_pkg::CADDR_W-1:0]    waddr,
  input  logic [CW-1:0]                   wdata,
  output logic [TAPS-1:0][CW-1:0]         mem_q
);
  import pfir_pkg::*;

  for (genvar i = 0; i < TAPS; i++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == CADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[i] <= '0;
      else if (hit) mem_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/pfir_hist.sv
module pfir_hist #(
  parameter int DEPTH = 12,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DW-1:0]            din,
  output logic [DEPTH-1:0][DW-1:0] taps_q
);
  logic [DEPTH-1:0][DW-1:0] taps_d;

  always_comb begin
    taps_d = taps_q;
    if (push) begin
      taps_d[0] = din;
      for (int i = 1; i < DEPTH; i++) taps_d[i] = taps_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= taps_d;
  end
endmodule

// File: rtl/pfir_slice.sv
module pfir_slice #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          run,
  input  logic [DW-1:0] feed,
  input  logic [CW-1:0] coef,
  output logic [DW-1:0] samp_q,
  output logic [AW-1:0] acc_q
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0] prod;
  logic [DW-1:0]        samp_d;
  logic [AW-1:0]        acc_d;

  assign prod = $signed(samp_q) * $signed(coef);

  always_comb begin
    samp_d = samp_q;
    acc_d  = acc_q;
    if (load) begin
      samp_d = feed;
      acc_d  = '0;
    end else if (run) begin
      samp_d = feed;
      acc_d  = acc_q + {{(AW-PW){prod[PW-1]}}, prod};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      acc_q  <= '0;
    end else begin
      samp_q <= samp_d;
      acc_q  <= acc_d;
    end
  end
endmodule

// File: rtl/pfir_slice_array.sv
module pfir_slice_array #(
  parameter int P    = 8,
  parameter int TAPS = 5,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 40
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         coef_we,
  input  logic [pfir_pkg::CADDR_W-1:0] coef_addr,
  input  logic [CW-1:0]                coef_data,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [DW-1:0]                in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [AW-1:0]                out_data
);
  import pfir_pkg::*;

  localparam int DEPTH   = P + TAPS - 1;
  localparam int CNT_MAX = (P > TAPS) ? P : TAPS;
  localparam int CNT_W   = $clog2(CNT_MAX) + 1;

  logic [1:0]                rsync_q;
  logic                      rst_i;
  pfir_state_e               state_q, state_d;
  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic                      in_fire, out_fire, load, run;
  logic [TAPS-1:0][CW-1:0]   coef_mem;
  logic [DEPTH-1:0][DW-1:0]  hist_q;
  logic [CW-1:0]             coef_sel;
  logic [DW-1:0]             new_samp;
  logic [P-1:0][DW-1:0]      feed, samp_q;
  logic [P-1:0][AW-1:0]      acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  assign in_ready  = (state_q == ST_FILL) && rst_i;
  assign out_valid = (state_q == ST_EMIT);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign load      = (state_q == ST_LOAD);
  assign run       = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_FILL: if (in_fire) begin
        if (cnt_q == CNT_W'(P-1)) begin
          state_d = ST_LOAD;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_LOAD: begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        if (cnt_q == CNT_W'(TAPS-1)) begin
          state_d = ST_EMIT;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_EMIT: if (out_fire) begin
        if (cnt_q == CNT_W'(P-1)) begin
          state_d = ST_FILL;
          cnt_d   = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_FILL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  pfir_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
    .clk(clk), .rst_n(rst_i), .we(coef_we), .waddr(coef_addr),
    .wdata(coef_data), .mem_q(coef_mem)
  );

  pfir_hist #(.DEPTH(DEPTH), .DW(DW)) u_hist (
    .clk(clk), .rst_n(rst_i), .push(in_fire), .din(in_data), .taps_q(hist_q)
  );

  // broadcast coefficient and the next older sample for slice 0
  always_comb begin
    coef_sel = '0;
    for (int i = 0; i < TAPS; i++)
      if (cnt_q == CNT_W'(i)) coef_sel = coef_mem[i];
    new_samp = '0;
    for (int i = 0; i < TAPS-1; i++)
      if (cnt_q == CNT_W'(i)) new_samp = hist_q[P+i];
  end

  for (genvar j = 0; j < P; j++) begin : g_slice
    if (j == 0) begin : g_head
      assign feed[j] = load ? hist_q[P-1] : new_samp;
    end else begin : g_link
      assign feed[j] = load ? hist_q[P-1-j] : samp_q[j-1];
    end
    pfir_slice #(.DW(DW), .CW(CW), .AW(AW)) u_slice (
      .clk(clk), .rst_n(rst_i), .load(load), .run(run), .feed(feed[j]),
      .coef(coef_sel), .samp_q(samp_q[j]), .acc_q(acc_q[j])
    );
  end

  always_comb begin
    out_data = '0;
    for (int i = 0; i < P; i++)
      if (cnt_q == CNT_W'(i)) out_data = acc_q[i];
  end
endmodule

// File: rtl/pfir_slice_array_chk.sv
module pfir_slice_array_chk #(
  parameter int P    = 8,
  parameter int TAPS = 5,
  parameter int CW   = 16,
  parameter int AW   = 40
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         coef_we,
  input logic [pfir_pkg::CADDR_W-1:0] coef_addr,
  input logic                         in_valid,
  input logic                         in_ready,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [AW-1:0]                out_data,
  input logic [TAPS-1:0][CW-1:0]      coef_mem
);
  localparam int PC_W = $clog2(P) + 1;

  logic [PC_W-1:0] in_cnt, out_cnt;
  logic [7:0]      wait_cnt;
  logic            in_fire, out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt   <= '0;
      out_cnt  <= '0;
      wait_cnt <= '0;
    end else begin
      if (in_fire)  in_cnt  <= (in_cnt == PC_W'(P-1)) ? '0 : in_cnt + 1'b1;
      if (out_fire) out_cnt <= (out_cnt == PC_W'(P-1)) ? '0 : out_cnt + 1'b1;
      if (in_fire && in_cnt == PC_W'(P-1)) wait_cnt <= '0;
      else if (wait_cnt != 8'hFF)          wait_cnt <= wait_cnt + 1'b1;
    end
  end

  p_fill_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_cnt == PC_W'(P-1) |=> !in_ready);

  p_emit_reopen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_cnt == PC_W'(P-1) |=> in_ready && !out_valid);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> wait_cnt == 8'(TAPS + 1));

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_coef_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we && coef_addr >= pfir_pkg::CADDR_W'(TAPS) |=> $stable(coef_mem));

  p_streams_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

bind pfir_slice_array pfir_slice_array_chk #(.P(P), .TAPS(TAPS), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .coef_mem(coef_mem)
);

// File: tb/pfir_slice_array_bench.sv
module pfir_slice_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P    = 8;
  localparam int TAPS = 5;

  logic        clk, rst_n, coef_we, in_valid, in_ready, out_valid, out_ready;
  logic [5:0]  coef_addr;
  logic [15:0] coef_data, in_data;
  logic [39:0] out_data;

  pfir_slice_array #(.P(P), .TAPS(TAPS)) u_pfir_slice_array (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag = "R1";

  // behavioural model state
  int          h[TAPS];
  longint      xs[$];
  logic [39:0] expq[$];
  int phase = 0;  // 0 taking samples, 1 computing, 2 emitting
  int fcnt = 0, wcnt = 0, eidx = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_tag, what, act, exp);
    end
  endtask

  task automatic compute_pass();
    int base = xs.size() - P;
    for (int j = 0; j < P; j++) begin
      longint s = 0;
      for (int k = 0; k < TAPS; k++)
        if (base + j - k >= 0) s += longint'(h[k]) * xs[base + j - k];
      expq.push_back(s[39:0]);
    end
  endtask

  task automatic cycle(input bit iv, input logic [15:0] id, input bit ordy,
                       input bit cwe, input logic [5:0] ca, input logic [15:0] cd);
    @(negedge clk);
    check(in_ready == (phase == 0), (phase == 1) ? "R2 in_ready while computing" : "R2 in_ready",
          longint'(in_ready), longint'(phase == 0));
    check(out_valid == (phase == 2), (phase == 1) ? "R5 out_valid timing" : "R6 out_valid",
          longint'(out_valid), longint'(phase == 2));
    check(!(in_ready && out_valid), "R9 both streams open", longint'(in_ready && out_valid), 0);
    if (phase == 2 && out_valid)
      check(out_data == expq[eidx], $sformatf("R3 R4 output %0d", eidx),
            longint'($signed(out_data)), longint'($signed(expq[eidx])));
    in_valid  = iv;
    in_data   = id;
    out_ready = ordy;
    coef_we   = cwe;
    coef_addr = ca;
    coef_data = cd;
    #1;
    if (cwe && ca < 6'(TAPS)) h[ca] = int'($signed(cd));
    case (phase)
      0: if (iv) begin
        xs.push_back(longint'($signed(id)));
        fcnt++;
        if (fcnt == P) begin
          fcnt = 0;
          compute_pass();
          phase = 1;
          wcnt = TAPS + 1;
        end
      end
      1: begin
        wcnt--;
        if (wcnt == 0) phase = 2;
      end
      default: if (ordy) begin
        eidx++;
        if (eidx == P) begin
          eidx = 0;
          expq.delete();
          phase = 0;
        end
      end
    endcase
  endtask

  task automatic wr_coef(input logic [5:0] a, input int v);
    cycle(1'b0, '0, 1'b1, 1'b1, a, 16'(v));
  endtask

  task automatic run_pass(input logic [15:0] s[P], input bit gaps, input bit stalls);
    int sent = 0;
    while (sent < P) begin
      bit iv = gaps ? 1'($urandom_range(0, 1)) : 1'b1;
      cycle(iv, s[sent], 1'b1, 1'b0, '0, '0);
      if (iv) sent++;
    end
    while (phase != 0) begin
      bit r = stalls ? 1'($urandom_range(0, 1)) : 1'b1;
      cycle(1'b0, '0, r, 1'b0, '0, '0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_tag);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] s[P];
    for (int k = 0; k < TAPS; k++) h[k] = 0;
    rst_n = 1'b0; coef_we = 1'b0; coef_addr = '0; coef_data = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1: both streams closed during reset
    cur_tag = "R1";
    check(!in_ready, "R1 in_ready in reset", longint'(in_ready), 0);
    check(!out_valid, "R1 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready, "R1 in_ready after release", longint'(in_ready), 1);

    // R1: zero coefficients after reset give zero results
    for (int i = 0; i < P; i++) s[i] = 16'(100 + i);
    run_pass(s, 1'b0, 1'b0);

    // R4: impulse filter reproduces the samples in order
    cur_tag = "R4";
    wr_coef(6'd0, 1);
    for (int i = 0; i < P; i++) s[i] = 16'(i + 1);
    run_pass(s, 1'b0, 1'b0);

    // R7: in-range writes apply, out-of-range writes are ignored
    cur_tag = "R7";
    for (int k = 0; k < TAPS; k++) wr_coef(6'(k), k + 1);
    wr_coef(6'(TAPS), 999);
    wr_coef(6'd63, -999);
    for (int i = 0; i < P; i++) s[i] = 16'(3 * i - 7);
    run_pass(s, 1'b0, 1'b0);

    // R2 R6: random gaps on input, random stalls on output
    cur_tag = "R6";
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < P; i++) s[i] = 16'($urandom);
      run_pass(s, 1'b1, 1'b1);
    end

    // R3: full-scale negative operands need more than 32 bits
    cur_tag = "R3";
    for (int k = 0; k < TAPS; k++) wr_coef(6'(k), -32768);
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < P; i++) s[i] = 16'h8000;
      run_pass(s, 1'b0, 1'b1);
    end

    // R8: mixed signs over several passes, history continues
    cur_tag = "R8";
    wr_coef(6'd0, -1); wr_coef(6'd1, 32767); wr_coef(6'd2, -20000);
    wr_coef(6'd3, 12345); wr_coef(6'd4, 7);
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < P; i++) s[i] = 16'($urandom);
      run_pass(s, p[0], p[1]);
    end

    cur_tag = "R9";
    repeat (4) cycle(1'b0, '0, 1'b1, 1'b0, '0, '0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule